// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers a set of external interrupt sources and distributes them to several targets, where every privilege mode of every hart counts as a separate target. Each source passes through a gateway that converts its level signal into one request, latched as a pending bit. The gateway then stays closed until software signals that servicing is done. For every target the block finds the highest-priority source that is pending and enabled for that target. It raises that target's interrupt line when the winning priority is strictly above the target's threshold.

Software reaches the block through a simple word-addressed register port. It holds one priority per source, one enable mask per target and one threshold per target. It also has a claim/complete register per target. Reading the claim register returns the winning source ID and removes that source's pending bit. All accesses go through the single port one at a time, so two targets can never both receive the same request. Writing a source ID to the same register ends servicing and reopens that source's gateway. Source ID 0 is reserved and means "no interrupt".

Top module: `plic_core`

## Requirements
- R1: While source s's input is high and its gateway is open, its pending bit is set at the next clock edge. The pending register (word address 0x080) shows source s at bit s, and bit 0 is always 0.
- R2: Once a source has forwarded a request, a high input sets no new pending bit until a completion carrying that source's ID is written.
- R3: The priority of source s (1..NSRC) is at word address 0x000+s, PRIO_W bits wide. A source with priority 0 never raises an interrupt line and is never returned by a claim.
- R4: The enable mask of target t is at word address 0x100+t, with bit s enabling source s. A source that is not enabled for a target plays no part in that target's line or claim.
- R5: irq_o[t] is high exactly when the largest priority among sources that are pending, enabled for t and of nonzero priority is strictly greater than the threshold of t (word address 0x200+t).
- R6: Among eligible sources of equal top priority, the lowest source ID wins.
- R7: A read of the claim register of target t (word address 0x300+t) returns the winning source ID and clears that source's pending bit. With no eligible source it returns 0.
- R8: Claims are serialized, so a source claimed by one target is not returned by a later claim from another target.
- R9: Writing source ID s to any target's claim register reopens gateway s. Written values of 0 or above NSRC have no effect.
- R10: After reset, all priorities, enables, thresholds, pending bits and gateway states are 0, and every interrupt line is low.
- R11: Read data appears on bus_rdata one clock edge after the read is presented. Priority, enable and threshold registers read back the value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Raw source levels; bit i is source ID i+1 |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word address: group in [11:8], index in [7:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | NTGT | Interrupt notification line per target |

## Verification
A high source input becomes pending at the first edge after it is driven. The interrupt lines are combinational from the registered state, so they are valid right after that same edge. Claim data arrives on bus_rdata at the edge that samples the read, and the pending bit clears at that same edge. A completion reopens the gateway at one edge, and a still-high input becomes pending again at the following edge. The bench drives each access on a falling edge and samples results on the next falling edge. Where a completion is involved, it waits one extra falling edge before reading pending state.

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC   = 7,
  parameter int NTGT   = 2,
  parameter int PRIO_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic             bus_en,
  input  logic             bus_we,
  input  logic [11:0]      bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic [NTGT-1:0]  irq_o
);
  localparam int ID_W = $clog2(NSRC + 1);

  logic [PRIO_W-1:0] prio [NSRC:1];
  logic [NSRC:1]     en   [NTGT];
  logic [PRIO_W-1:0] thr  [NTGT];
  logic [NSRC:1]     pend, busy;
  logic [ID_W-1:0]   win_id [NTGT];
  logic [PRIO_W-1:0] win_pr [NTGT];
  logic [31:0]       rd_next;

  wire       rd  = bus_en & ~bus_we;
  wire       wr  = bus_en &  bus_we;
  wire [3:0] grp = bus_addr[11:8];
  wire [7:0] idx = bus_addr[7:0];

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      win_id[t] = '0;
      win_pr[t] = '0;
      for (int s = 1; s <= NSRC; s++)
        if (pend[s] && en[t][s] && prio[s] > win_pr[t]) begin
          win_pr[t] = prio[s];
          win_id[t] = ID_W'(s);
        end
    end
  end

  always_comb
    for (int t = 0; t < NTGT; t++) irq_o[t] = win_pr[t] > thr[t];

  always_comb begin
    rd_next = '0;
    case (grp)
      4'd0: begin
        if (idx == 8'h80) rd_next = 32'({pend, 1'b0});
        for (int s = 1; s <= NSRC; s++)
          if (idx == 8'(s)) rd_next = 32'(prio[s]);
      end
      4'd1: for (int t = 0; t < NTGT; t++) if (idx == 8'(t)) rd_next = 32'({en[t], 1'b0});
      4'd2: for (int t = 0; t < NTGT; t++) if (idx == 8'(t)) rd_next = 32'(thr[t]);
      4'd3: for (int t = 0; t < NTGT; t++) if (idx == 8'(t)) rd_next = 32'(win_id[t]);
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      busy      <= '0;
      bus_rdata <= '0;
      for (int s = 1; s <= NSRC; s++) prio[s] <= '0;
      for (int t = 0; t < NTGT; t++) begin
        en[t]  <= '0;
        thr[t] <= '0;
      end
    end else begin
      for (int s = 1; s <= NSRC; s++) begin
        if (wr && grp == 4'd3 && idx < 8'(NTGT) && bus_wdata == 32'(s))
          busy[s] <= 1'b0;
        if (src_i[s-1] && !busy[s]) begin
          pend[s] <= 1'b1;
          busy[s] <= 1'b1;
        end
      end
      if (rd) begin
        bus_rdata <= rd_next;
        if (grp == 4'd3)
          for (int t = 0; t < NTGT; t++)
            if (idx == 8'(t))
              for (int s = 1; s <= NSRC; s++)
                if (win_id[t] == ID_W'(s)) pend[s] <= 1'b0;
      end
      if (wr) begin
        if (grp == 4'd0)
          for (int s = 1; s <= NSRC; s++)
            if (idx == 8'(s)) prio[s] <= bus_wdata[PRIO_W-1:0];
        for (int t = 0; t < NTGT; t++)
          if (idx == 8'(t)) begin
            if (grp == 4'd1) en[t]  <= bus_wdata[NSRC:1];
            if (grp == 4'd2) thr[t] <= bus_wdata[PRIO_W-1:0];
          end
      end
    end
  end
endmodule

module plic_core_chk #(
  parameter int NSRC = 7,
  parameter int NTGT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_i,
  input logic            bus_en,
  input logic            bus_we,
  input logic [11:0]     bus_addr,
  input logic [31:0]     bus_rdata,
  input logic [NTGT-1:0] irq_o,
  input logic [NSRC:1]   pend,
  input logic [NSRC:1]   busy
);
  localparam int ID_W = $clog2(NSRC + 1);
  wire [NSRC:0] pend_w   = {pend, 1'b0};
  wire          claim_rd = bus_en && !bus_we && bus_addr[11:8] == 4'd3 && bus_addr[7:0] < 8'(NTGT);

  a_r1_pend_from_src: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(src_i)) == '0);

  a_r2_pend_holds_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~busy) == '0);

  a_r5_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|pend));

  a_r7_id_range: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> bus_rdata <= 32'(NSRC));

  a_r7_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    claim_rd |=> (bus_rdata == 0) ||
                 (bus_rdata <= 32'(NSRC) && !pend_w[bus_rdata[ID_W-1:0]]));
endmodule

bind plic_core plic_core_chk #(.NSRC(NSRC), .NTGT(NTGT)) u_chk (.*);

// File: tb/plic_core_bench.sv
`timescale 1ns/1ps
module plic_core_bench;
  localparam int NSRC = 7, NTGT = 2;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic            bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0]     bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NTGT-1:0] irq_o;

  int tests = 0, fails = 0;
  int pr [8] = '{0, 2, 5, 5, 0, 3, 7, 1};
  int enm [NTGT] = '{32'hFE, 32'h2E};
  int th  [NTGT] = '{0, 4};

  plic_core u_plic_core (.*);

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    bus_en = 1; bus_we = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(int a, output int d);
    bus_en = 1; bus_we = 0; bus_addr = 12'(a);
    @(negedge clk);
    d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; src_i = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic configure();
    for (int s = 1; s <= NSRC; s++) wr(s, pr[s]);
    for (int t = 0; t < NTGT; t++) begin
      wr(32'h100 + t, enm[t]);
      wr(32'h200 + t, th[t]);
    end
  endtask

  function automatic int best(int t, int pm, output int bp);
    int id = 0;
    bp = 0;
    for (int s = 1; s <= NSRC; s++)
      if (pm[s] && enm[t][s] && pr[s] > bp) begin bp = pr[s]; id = s; end
    return id;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, bp, id;
    @(negedge clk);
    do_reset();
    // R10 reset state
    chk("R10 irq after reset", int'(irq_o), 0);
    rd(32'h080, d); chk("R10 pending after reset", d, 0);
    rd(32'h001, d); chk("R10 priority after reset", d, 0);
    rd(32'h300, d); chk("R10 claim after reset", d, 0);

    configure();
    // R11 readback
    rd(32'h006, d); chk("R11 priority readback", d, 7);
    rd(32'h101, d); chk("R11 enable readback", d, 32'h2E);
    rd(32'h201, d); chk("R11 threshold readback", d, 4);

    // R2 / R9 gateway hold and release
    src_i = 7'b0000001;
    @(negedge clk);
    rd(32'h080, d); chk("R1 pending set", d, 2);
    rd(32'h300, d); chk("R7 claim source 1", d, 1);
    repeat (3) @(negedge clk);
    rd(32'h080, d); chk("R2 no re-request before completion", d, 0);
    wr(32'h300, 0);
    wr(32'h301, 9);
    @(negedge clk);
    rd(32'h080, d); chk("R9 bad completion ignored", d, 0);
    wr(32'h301, 1);
    @(negedge clk);
    rd(32'h080, d); chk("R9 completion reopens gateway", d, 2);

    // Exhaustive sweep over source patterns: R3 R4 R5 R6 R7 R8
    for (int m = 0; m < (1 << NSRC); m++) begin
      int pm;
      do_reset();
      configure();
      src_i = NSRC'(m);
      @(negedge clk);
      pm = m << 1;
      for (int t = 0; t < NTGT; t++) begin
        id = best(t, pm, bp);
        chk("R5 irq vs threshold", int'(irq_o[t]), int'(bp > th[t]));
      end
      rd(32'h080, d); chk("R1 pending pattern", d, pm);
      id = best(0, pm, bp);
      rd(32'h300, d); chk("R6 R7 claim winner target 0", d, id);
      if (id != 0) pm[id] = 1'b0;
      id = best(1, pm, bp);
      rd(32'h301, d); chk("R4 R8 claim winner target 1", d, id);
      if (id != 0) pm[id] = 1'b0;
      rd(32'h080, d); chk("R7 pending after claims", d, pm);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule